// File: doc/BRIEF.md
# Dual-Mode Four-Phase Handshake Link

This block carries parallel words between two units that run on unrelated clocks. It has two cooperating state machines. The source side sits in the sending clock domain and takes words from a local valid/ready port. The destination side sits in the receiving clock domain and presents each word it captures on a local output, flagged by a one-cycle pulse. Two control wires and a data bus connect the two sides. Each side passes the control wire it receives through its own chain of synchronizer flops before acting on it.

The handshake is four-phase and has two modes. In source-initiated mode the source raises a valid wire, and the destination answers on its control wire to say the word has been accepted. In destination-initiated mode the same control wire means the destination is ready for data, and the source may not present a word until it has seen it. The sequence of edges is the same in both modes. The only difference is the state in which the destination's control wire sits while the link is idle. The mode is chosen at a static input that is held constant between resets.

Top module: `hs_link_top`

## Requirements
- R1: While either reset is asserted, and directly after it, `src_ready_o` is 1, `dst_valid_o` is 0, and both control wires are low.
- R2: The source takes a word only when it is idle, shown by `src_ready_o` = 1. From the acceptance edge until its handshake has completed, `src_ready_o` stays 0.
- R3: The source places the word on the bus at least one source cycle before the valid wire rises. The bus then holds its value for as long as valid stays high.
- R4: Mode 0 (source-initiated). The destination raises its control wire (data accepted) only in the cycle in which it captures the word. The source drops valid only after it has seen that wire high. The destination drops the wire only after it has seen valid low.
- R5: Mode 1 (destination-initiated). The destination raises its control wire (ready for data) while idle. The source raises valid only while that wire is high.
- R6: Mode 1. The destination drops ready when it captures the word. The source drops valid only after it has seen ready low. The destination raises ready again only after it has seen valid low.
- R7: Each captured word appears on `dst_data_o` with a single-cycle `dst_valid_o` pulse. Words arrive in the order they were accepted, with none lost or repeated.
- R8: Each side acts on the opposite side's control wire only after `SYNC_STAGES` flops in its own clock. So a word cannot be delivered earlier than one source cycle plus `SYNC_STAGES` destination cycles after it was accepted.
- R9: `mode_i` = 0 selects source-initiated operation and `mode_i` = 1 selects destination-initiated operation. The value must be held constant while both resets are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source-side clock |
| src_rst_ni | input | 1 | Source-side asynchronous reset, active low |
| dst_clk_i | input | 1 | Destination-side clock |
| dst_rst_ni | input | 1 | Destination-side asynchronous reset, active low |
| mode_i | input | 1 | 0: source-initiated, 1: destination-initiated |
| src_valid_i | input | 1 | Local word offered to the source |
| src_data_i | input | DATA_W | Local word to send |
| src_ready_o | output | 1 | Source idle, word taken on this edge if offered |
| dst_data_o | output | DATA_W | Last captured word |
| dst_valid_o | output | 1 | One-cycle pulse when a new word is captured |

## Verification
The bench builds the link with DATA_W = 12 and SYNC_STAGES = 2. It clocks the two sides at 10 ns and 17 ns, so the sampling phase between the domains walks through every offset over a run. The 12-bit width makes all-zero, all-one and alternating bit patterns short to cover, while the bus is still wide enough that a mis-timed capture produces a visibly wrong word. With two synchronizer stages, the lower bound on delivery latency sits well above what a single stage would give, so losing a stage shows up as a word that arrives too early.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    SRC_IDLE, SRC_WAIT, SRC_SETUP, SRC_VALID, SRC_DROP
  } src_state_e;

  typedef enum logic [1:0] {
    DST_IDLE, DST_RDY, DST_ACK, DST_DONE
  } dst_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_src.sv
module hs_src
  import hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              word_ready_o,
  input  logic              ack_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              valid_o
);
  src_state_e        state_q, state_d;
  logic              ack_s;
  logic [DATA_W-1:0] hold_q, bus_q;
  logic              valid_q;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_IDLE:  if (word_valid_i) state_d = mode_i ? SRC_WAIT : SRC_SETUP;
      SRC_WAIT:  if (ack_s) state_d = SRC_SETUP;
      SRC_SETUP: state_d = SRC_VALID;
      // mode 0 waits for accept high, mode 1 for ready low
      SRC_VALID: if (mode_i ? !ack_s : ack_s) state_d = SRC_DROP;
      SRC_DROP:  if (mode_i || !ack_s) state_d = SRC_IDLE;
      default:   state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_IDLE;
      hold_q  <= '0;
      bus_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= (state_d == SRC_VALID);
      if (state_q == SRC_IDLE && word_valid_i) hold_q <= word_i;
      if (state_d == SRC_SETUP && state_q != SRC_SETUP)
        bus_q <= (state_q == SRC_IDLE) ? word_i : hold_q;
    end
  end

  assign word_ready_o = (state_q == SRC_IDLE);
  assign bus_o        = bus_q;
  assign valid_o      = valid_q;
endmodule

// File: rtl/hs_dst.sv
module hs_dst
  import hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o
);
  dst_state_e        state_q, state_d;
  logic              valid_s, capture;
  logic              ack_q, word_valid_q;
  logic [DATA_W-1:0] word_q;

  hs_sync #(.STAGES(SYNC_STAGES)) u_valid_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(valid_i), .q_o(valid_s)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DST_IDLE: begin
        if (mode_i && !valid_s)      state_d = DST_RDY;
        else if (!mode_i && valid_s) state_d = DST_ACK;
      end
      DST_RDY:  if (valid_s)  state_d = DST_DONE;
      DST_ACK:  if (!valid_s) state_d = DST_IDLE;
      DST_DONE: if (!valid_s) state_d = DST_IDLE;
      default:  state_d = DST_IDLE;
    endcase
  end

  assign capture = (state_q == DST_IDLE && state_d == DST_ACK) ||
                   (state_q == DST_RDY  && state_d == DST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= DST_IDLE;
      ack_q        <= 1'b0;
      word_q       <= '0;
      word_valid_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      ack_q        <= (state_d == DST_ACK) || (state_d == DST_RDY);
      word_valid_q <= capture;
      if (capture) word_q <= bus_i;
    end
  end

  assign ack_o        = ack_q;
  assign word_o       = word_q;
  assign word_valid_o = word_valid_q;
endmodule

// File: rtl/hs_link_top.sv
module hs_link_top #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk_i,
  input  logic              src_rst_ni,
  input  logic              dst_clk_i,
  input  logic              dst_rst_ni,
  input  logic              mode_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              dst_valid_o
);
  logic              valid_w, ack_w;
  logic [DATA_W-1:0] bus_w;

  hs_src #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i(src_clk_i), .rst_ni(src_rst_ni), .mode_i(mode_i),
    .word_valid_i(src_valid_i), .word_i(src_data_i), .word_ready_o(src_ready_o),
    .ack_i(ack_w), .bus_o(bus_w), .valid_o(valid_w)
  );

  hs_dst #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dst (
    .clk_i(dst_clk_i), .rst_ni(dst_rst_ni), .mode_i(mode_i),
    .valid_i(valid_w), .bus_i(bus_w), .ack_o(ack_w),
    .word_o(dst_data_o), .word_valid_o(dst_valid_o)
  );
endmodule

// File: rtl/hs_link_chk.sv
module hs_link_chk #(
  parameter int DATA_W = 16
) (
  input logic              src_clk_i,
  input logic              src_rst_ni,
  input logic              dst_clk_i,
  input logic              dst_rst_ni,
  input logic              mode_i,
  input logic              valid_w,
  input logic              ack_w,
  input logic [DATA_W-1:0] bus_w,
  input logic              src_ready_o,
  input logic              dst_valid_o
);
  // R3
  bus_setup_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    $rose(valid_w) |-> $stable(bus_w));
  // R3
  bus_hold_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    valid_w |=> (!valid_w || $stable(bus_w)));
  // R2
  ready_idle_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    src_ready_o |-> !valid_w);
  // R4
  accept_after_capture_chk: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    (!mode_i && $rose(ack_w)) |-> dst_valid_o);
  // R4
  drop_after_accept_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (!mode_i && $fell(valid_w)) |-> ack_w);
  // R5
  valid_needs_ready_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (mode_i && $rose(valid_w)) |-> ack_w);
  // R6
  drop_after_unready_chk: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    (mode_i && $fell(valid_w)) |-> !ack_w);
  // R7
  single_pulse_chk: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    dst_valid_o |=> !dst_valid_o);
endmodule

bind hs_link_top hs_link_chk #(.DATA_W(DATA_W)) u_chk (
  .src_clk_i(src_clk_i), .src_rst_ni(src_rst_ni),
  .dst_clk_i(dst_clk_i), .dst_rst_ni(dst_rst_ni),
  .mode_i(mode_i), .valid_w(valid_w), .ack_w(ack_w), .bus_w(bus_w),
  .src_ready_o(src_ready_o), .dst_valid_o(dst_valid_o)
);

// File: tb/sim_hs_link_top.sv
module sim_hs_link_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int  CLK_PERIOD  = 10;
  localparam real DST_PERIOD  = 17.0;
  localparam int  DATA_W      = 12;
  localparam int  SYNC_STAGES = 2;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic mode = 1'b0;
  logic src_valid = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic src_ready, dst_valid;
  logic [DATA_W-1:0] dst_data;

  int n_chk = 0, n_fail = 0, n_tx = 0, n_rx = 0;
  logic [DATA_W-1:0] exp_q[$];
  realtime           t_q[$];

  always #(CLK_PERIOD / 2.0) src_clk = ~src_clk;
  always #(DST_PERIOD / 2.0) dst_clk = ~dst_clk;

  hs_link_top #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u0 (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n),
    .mode_i(mode), .src_valid_i(src_valid), .src_data_i(src_data),
    .src_ready_o(src_ready), .dst_data_o(dst_data), .dst_valid_o(dst_valid)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // driver: offer a word, wait for acceptance, push expectation
  task automatic send(input logic [DATA_W-1:0] w);
    forever begin
      @(negedge src_clk);
      if (src_ready) begin
        src_valid = 1'b1;
        src_data  = w;
        @(posedge src_clk);
        exp_q.push_back(w);
        t_q.push_back($realtime);
        n_tx++;
        @(negedge src_clk);
        src_valid = 1'b0;
        src_data  = ~w;
        chk(src_ready == 1'b0, "R2 ready low after accept", src_ready, 0);
        break;
      end
    end
  endtask

  // monitor: compare captured words in order
  always @(negedge dst_clk) begin
    if (dst_rst_n && dst_valid) begin
      n_rx++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected word", dst_data, 0);
      end else begin
        automatic logic [DATA_W-1:0] e = exp_q.pop_front();
        automatic realtime ta = t_q.pop_front();
        chk(dst_data == e, mode ? "R5 R7 word (mode 1)" : "R4 R7 word (mode 0)", dst_data, e);
        chk(($realtime - ta) >= (CLK_PERIOD + SYNC_STAGES * DST_PERIOD),
            "R8 R3 delivery latency", longint'($realtime - ta),
            longint'(CLK_PERIOD + SYNC_STAGES * DST_PERIOD));
      end
    end
  end

  task automatic apply_reset(input logic m);
    @(negedge src_clk);
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    src_valid = 1'b0;
    mode      = m;
    repeat (4) @(negedge src_clk);
    chk(src_ready == 1'b1, "R1 ready in reset", src_ready, 1);
    chk(dst_valid == 1'b0, "R1 no output pulse in reset", dst_valid, 0);
    src_rst_n = 1'b1;
    @(negedge dst_clk);
    dst_rst_n = 1'b1;
    @(negedge src_clk);
    chk(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge src_clk);
    repeat (20) @(negedge src_clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    chk(src_ready == 1'b1, tag, src_ready, 1);
  endtask

  task automatic run_patterns(input int base);
    send('0);
    send('1);
    send({(DATA_W/2){2'b10}});
    send({(DATA_W/2){2'b01}});
    for (int i = 0; i < 12; i++) send(DATA_W'(base + i * 37));
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    chk(1'b0, "R7 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R9 mode 0: source-initiated
    apply_reset(1'b0);
    run_patterns(12'h013);
    drain("R4 mode 0 handshake completes");
    // R9 mode 1: destination-initiated
    apply_reset(1'b1);
    repeat (40) @(negedge src_clk);
    chk(n_rx == n_tx, "R5 no word while source idle", n_rx, n_tx);
    run_patterns(12'h7c1);
    drain("R6 mode 1 handshake completes");
    repeat (40) @(negedge src_clk);
    chk(n_rx == n_tx, "R7 word count", n_rx, n_tx);
    summary();
    $finish;
  end
endmodule